// File: doc/BRIEF.md
# Inverted Double-Start Serial Transmitter

This block sends bytes one at a time on a single serial line, using a custom asynchronous frame. A byte enters through a valid/ready handshake. A programmable number of idle cycles is then inserted. After that the frame goes out in thirteen equal slots:

- a low start slot, then a high start slot;
- a zero slot for framing;
- the eight bits of the complemented byte, most significant bit first;
- a trailing zero slot;
- a high stop slot.

Every slot lasts the same programmable number of clock cycles. The line rests high whenever no frame is running. A producer holds its byte on the input until the block takes it. Both the slot length and the inter-byte gap are captured when the byte is accepted. Later changes to either input therefore affect only later frames.

Top module: `dstx`

## Requirements
- R1: After reset, and whenever no byte is being handled, `tx_line` is 1 and `in_ready` is 1.
- R2: A byte is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the edge after acceptance until the stop slot has finished, and it is 1 again on the following cycle. A byte offered while busy stays pending and is accepted at the first edge where `in_ready` is 1 again.
- R3: For exactly `gap_len` cycles after acceptance, `tx_line` stays 1. With `gap_len` equal to 0, the first start slot begins on the cycle right after acceptance.
- R4: Slot 0 drives 0 and slot 1 drives 1 (the double start).
- R5: Slot 2 drives 0. Slots 3 to 10 drive the bitwise complement of the accepted byte: slot 3 carries complemented bit 7 and slot 10 carries complemented bit 0.
- R6: Slot 11 drives 0 and slot 12 drives 1. `in_ready` returns to 1 only after slot 12 has finished.
- R7: Each slot lasts `bit_period` cycles. A `bit_period` of 0 is treated as 1.
- R8: `bit_period` and `gap_len` are sampled at acceptance. Changing them during a frame does not change that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_ready | output | 1 | Block can take a byte |
| bit_period | input | 16 | Cycles per slot, 0 treated as 1 |
| gap_len | input | 16 | Idle-high cycles between acceptance and the first start slot |
| tx_line | output | 1 | Serial output, idles high |

## Verification
The bench compares every cycle of each frame against an expected waveform that it builds itself. This catches three kinds of error:
- A data order reversal, or a missing complement, shows up as wrong levels in slots 3 to 10.
- An off-by-one in the slot counter stretches or shortens every slot by a cycle.
- A missing framing or trailing zero shifts the whole frame.

Gaps of zero and slot lengths of 0 and 1 are targeted directly, because a counter that compares against `period - 1` without guarding zero would wrap and hang. The bench rewrites both timing inputs in the middle of a frame, which exposes a design that reads them live. It also holds `in_valid` high across the end of a frame, which exposes one that drops the waiting byte or takes it one cycle early.

// File: rtl/dstx_pkg.sv
package dstx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_SEND = 2'd2
    } dstx_state_e;
endpackage

// File: rtl/dstx_slot_map.sv
module dstx_slot_map #(
    parameter int DATA_W = 8,
    parameter int SLOT_W = 4
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [DATA_W-1:0] inv_data,
    output logic              level
);
    localparam int DATA_BASE = 3;
    localparam int TAIL_SLOT = DATA_BASE + DATA_W;

    always_comb begin
        level = 1'b1;
        if (slot == SLOT_W'(0))              level = 1'b0;
        else if (slot == SLOT_W'(1))         level = 1'b1;
        else if (slot == SLOT_W'(2))         level = 1'b0;
        else if (slot == SLOT_W'(TAIL_SLOT)) level = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (slot == SLOT_W'(DATA_BASE + i)) level = inv_data[DATA_W-1-i];
        end
    end
endmodule

// File: rtl/dstx_seq.sv
module dstx_seq
    import dstx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CNT_W-1:0]  bit_period,
    input  logic [CNT_W-1:0]  gap_len,
    output logic              sending,
    output logic [SLOT_W-1:0] slot,
    output logic [DATA_W-1:0] inv_data
);
    localparam int LAST_SLOT = DATA_W + 4;

    typedef struct packed {
        dstx_state_e       st;
        logic [SLOT_W-1:0] slot;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  per;
        logic [CNT_W-1:0]  gap;
        logic [DATA_W-1:0] inv;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.inv  = ~in_data;
                    r_d.per  = (bit_period == '0) ? CNT_W'(1) : bit_period;
                    r_d.gap  = gap_len;
                    r_d.cnt  = '0;
                    r_d.slot = '0;
                    r_d.st   = (gap_len == '0) ? ST_SEND : ST_GAP;
                end
            end
            ST_GAP: begin
                if (r_q.cnt == r_q.gap - CNT_W'(1)) begin
                    r_d.cnt = '0;
                    r_d.st  = ST_SEND;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_SEND: begin
                if (r_q.cnt == r_q.per - CNT_W'(1)) begin
                    r_d.cnt = '0;
                    if (r_q.slot == SLOT_W'(LAST_SLOT)) r_d.st = ST_IDLE;
                    else r_d.slot = r_q.slot + SLOT_W'(1);
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.slot <= '0;
            r_q.cnt  <= '0;
            r_q.per  <= CNT_W'(1);
            r_q.gap  <= '0;
            r_q.inv  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready = (r_q.st == ST_IDLE);
    assign sending  = (r_q.st == ST_SEND);
    assign slot     = r_q.slot;
    assign inv_data = r_q.inv;

    // R2: an accepted byte makes the block busy on the next cycle
    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R8: captured timing holds for the whole frame
    assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> ($stable(r_q.per) && $stable(r_q.gap)));

    // R6: the slot index never runs past the stop slot
    assert_slot_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.slot <= SLOT_W'(LAST_SLOT));

    // R7: a running slot counter stays below the captured period
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SEND) |-> (r_q.cnt < r_q.per));
endmodule

// File: rtl/dstx.sv
module dstx #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CNT_W-1:0]  bit_period,
    input  logic [CNT_W-1:0]  gap_len,
    output logic              tx_line
);
    localparam int SLOT_W = $clog2(DATA_W + 5);

    logic              sending;
    logic [SLOT_W-1:0] slot;
    logic [DATA_W-1:0] inv_data;
    logic              level;

    dstx_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .bit_period (bit_period),
        .gap_len    (gap_len),
        .sending    (sending),
        .slot       (slot),
        .inv_data   (inv_data)
    );

    dstx_slot_map #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_map (
        .slot     (slot),
        .inv_data (inv_data),
        .level    (level)
    );

    assign tx_line = sending ? level : 1'b1;

    // R1: the line rests high while the block waits for a byte
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tx_line);

    // R4: the first start slot is always low
    assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && slot == '0) |-> !tx_line);
endmodule

// File: tb/dstx_test.sv
module dstx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] bit_period = 16'd1;
    logic [15:0] gap_len = '0;
    logic        tx_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dstx uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .bit_period(bit_period), .gap_len(gap_len),
        .tx_line(tx_line)
    );

    // Expected level of slot s for byte d
    function automatic logic exp_level(input int s, input logic [7:0] d);
        if (s == 0 || s == 2 || s == 11) return 1'b0;
        if (s == 1 || s == 12) return 1'b1;
        return ~d[10 - s];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive a byte; returns after the accepting edge
    task automatic offer(input logic [7:0] d, input int p, input int g);
        @(negedge clk);
        in_data = d; bit_period = 16'(p); gap_len = 16'(g); in_valid = 1'b1;
        @(posedge clk);
        while (!in_ready) @(posedge clk);
        #1;
    endtask

    // Check the frame cycle by cycle from the cycle after acceptance
    task automatic expect_frame(input logic [7:0] d, input int p, input int g, input string req);
        int pe = (p == 0) ? 1 : p;
        int bad_cyc = -1;
        logic bad_act = 1'b0, bad_exp = 1'b0;
        bit busy_ok = 1;
        for (int c = 0; c < g + 13 * pe; c++) begin
            logic e;
            @(negedge clk);
            e = (c < g) ? 1'b1 : exp_level((c - g) / pe, d);
            if (tx_line !== e && bad_cyc < 0) begin
                bad_cyc = c; bad_act = tx_line; bad_exp = e;
            end
            if (in_ready !== 1'b0) busy_ok = 0;
        end
        if (bad_cyc >= 0) $display("  frame mismatch at cycle %0d of byte %0h", bad_cyc, d);
        check(bad_cyc < 0, req, int'(bad_act), int'(bad_exp));
        check(busy_ok, "R2 busy", int'(busy_ok), 1);
        @(negedge clk);
        check(in_ready === 1'b1, "R6 ready after stop", int'(in_ready), 1);
    endtask

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(posedge clk);
        #1;
        check(tx_line === 1'b1 && in_ready === 1'b1, "R1 reset idle",
              int'({tx_line, in_ready}), 3);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_line === 1'b1 && in_ready === 1'b1, "R1 idle after reset",
              int'({tx_line, in_ready}), 3);

        // R4 R5 R6 directed: basic frame, slot length 1, no gap
        offer(8'hA5, 1, 0); in_valid = 1'b0;
        expect_frame(8'hA5, 1, 0, "R5 byte A5");

        // R7: period 0 acts as 1, R3 gap of 3
        offer(8'h01, 0, 3); in_valid = 1'b0;
        expect_frame(8'h01, 0, 3, "R7 period zero");

        // R8: change timing mid-frame
        offer(8'h80, 3, 2); in_valid = 1'b0; bit_period = 16'd7; gap_len = 16'd9;
        expect_frame(8'h80, 3, 2, "R8 mid-frame change");

        // R2: byte held while busy, accepted right after the stop slot
        offer(8'h3C, 2, 1);
        in_data = 8'hC3; bit_period = 16'd4; gap_len = 16'd0;
        expect_frame(8'h3C, 2, 1, "R2 first of pair");
        @(posedge clk); #1; in_valid = 1'b0;
        expect_frame(8'hC3, 4, 0, "R2 held byte");

        // R4 R5 extremes: all ones and all zeros
        offer(8'hFF, 2, 0); in_valid = 1'b0;
        expect_frame(8'hFF, 2, 0, "R4 byte FF");
        offer(8'h00, 1, 1); in_valid = 1'b0;
        expect_frame(8'h00, 1, 1, "R5 byte 00");

        // Random frames, R3 R7
        for (int n = 0; n < 25; n++) begin
            logic [7:0] d = 8'($urandom);
            int p = int'($urandom % 6);
            int g = int'($urandom % 5);
            offer(d, p, g); in_valid = 1'b0;
            expect_frame(d, p, g, "R3 random frame");
        end

        // R1: long idle keeps the line high
        repeat (20) @(negedge clk);
        check(tx_line === 1'b1 && in_ready === 1'b1, "R1 idle hold",
              int'({tx_line, in_ready}), 3);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                check(0, "watchdog", 0, 1);
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule